// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition Flags

This block is a purely combinational datapath unit. It takes two operand words and a two-bit function code and returns one result word along with four condition values: signed overflow, zero, negative (sign) and carry/borrow. It has no clock input and no storage. Every output follows its inputs after a propagation delay.

The unit offers four operations: addition, subtraction, bitwise AND and bitwise XOR. The flags always describe the operation currently selected. A neighbouring block decides whether and when to capture them into a condition register, and the unit itself never holds them. The operand width is a parameter with a default of 32 bits.

Top module: `alu_cc_unit`

## Requirements
- R1: With `op_sel` = 2'd0, `result` equals `opnd_x + opnd_y` modulo 2^32.
- R2: With `op_sel` = 2'd1, `result` equals `opnd_x - opnd_y` modulo 2^32.
- R3: With `op_sel` = 2'd2, `result` equals the bitwise AND of the operands.
- R4: With `op_sel` = 2'd3, `result` equals the bitwise XOR of the operands.
- R5: `flag_zero` is 1 exactly when every bit of `result` is 0, for all four codes.
- R6: `flag_neg` equals bit 31 (the top bit) of `result`, for all four codes.
- R7: For addition, `flag_ovf` is 1 exactly when both operands have the same top bit and the result's top bit is different.
- R8: For subtraction, `flag_ovf` is 1 exactly when the operands' top bits differ and the result's top bit differs from that of `opnd_x`.
- R9: For addition, `flag_carry` is the unsigned carry out of bit 31.
- R10: For subtraction, `flag_carry` is 1 exactly when `opnd_y` is greater than `opnd_x` as unsigned numbers, which is the borrow out of the top bit.
- R11: For AND and XOR, `flag_ovf` and `flag_carry` are both 0, whatever the operands are.
- R12: The outputs settle after an input change with no clock edge involved, and they change again when only `op_sel` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| opnd_x | input | 32 | First operand |
| opnd_y | input | 32 | Second operand |
| result | output | 32 | Selected result word |
| flag_ovf | output | 1 | Signed overflow of add/subtract, otherwise 0 |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Top bit of the result |
| flag_carry | output | 1 | Carry out for add, borrow for subtract, otherwise 0 |

## Verification
In this unit the carry/borrow path and the signed-overflow path can be active for the same operand pair. The zero flag can also coincide with a carry. Directed vectors provoke these cases: 0x7FFFFFFF+1 sets overflow without carry, 0x80000000+0x80000000 sets overflow, carry and zero together, and 0x80000000-1 sets overflow with no borrow. Each flag is compared against a reference model in the bench that works on wider unsigned integers and on explicit sign rules. A separate sweep holds the operands constant and changes only the function code, and it requires that overflow and carry drop to zero for the logic codes.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  localparam int unsigned FN_BITS = 2;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         ovf
);

  localparam int unsigned MSB = W - 1;

  function automatic logic [W:0] add_cin(input logic [W-1:0] p,
                                         input logic [W-1:0] q,
                                         input logic         cin);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic signed_ovf(input logic sa, input logic sb,
                                      input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  logic [W-1:0] b_eff;
  logic [W:0]   wide;
  logic         raw_carry;

  always_comb begin
    b_eff     = do_sub ? ~b : b;
    wide      = add_cin(a, b_eff, do_sub);
    sum       = wide[W-1:0];
    raw_carry = wide[W];
    carry_out = do_sub ? ~raw_carry : raw_carry;
    ovf       = signed_ovf(a[MSB], b_eff[MSB], sum[MSB]);

    if (!do_sub && b == '0) begin
      AST_ADD_IDENTITY: assert (sum == a && !carry_out && !ovf); // R1
    end
    if (do_sub && a == b) begin
      AST_SUB_SELF_ZERO: assert (sum == '0 && !carry_out && !ovf); // R10
    end
    if (!do_sub && ovf) begin
      AST_ADD_OVF_SIGNS: assert (a[MSB] == b[MSB] && sum[MSB] != a[MSB]); // R7
    end
    if (do_sub && ovf) begin
      AST_SUB_OVF_SIGNS: assert (a[MSB] != b[MSB] && sum[MSB] != a[MSB]); // R8
    end
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         pick_xor,
  output logic [W-1:0] out
);

  function automatic logic [W-1:0] bit_op(input logic [W-1:0] p,
                                          input logic [W-1:0] q,
                                          input logic         x);
    return x ? (p ^ q) : (p & q);
  endfunction

  always_comb begin
    out = bit_op(a, b, pick_xor);

    if (!pick_xor) begin
      AST_AND_SUBSET: assert ((out & ~a) == '0 && (out & ~b) == '0); // R3
    end
    if (pick_xor && a == b) begin
      AST_XOR_SELF: assert (out == '0); // R4
    end
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res,
  input  logic         arith_en,
  input  logic         carry_raw,
  input  logic         ovf_raw,
  output logic         zf,
  output logic         sf,
  output logic         cf,
  output logic         of
);

  function automatic logic all_clear(input logic [W-1:0] v);
    return ~|v;
  endfunction

  always_comb begin
    zf = all_clear(res);
    sf = res[W-1];
    cf = arith_en & carry_raw;
    of = arith_en & ovf_raw;

    if (zf) begin
      AST_ZERO_NOT_NEG: assert (!sf); // R5
    end
    if (!arith_en) begin
      AST_LOGIC_NO_CV: assert (!cf && !of); // R11
    end
  end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  output logic [WIDTH-1:0] result,
  output logic             flag_ovf,
  output logic             flag_zero,
  output logic             flag_neg,
  output logic             flag_carry
);

  import alu_cc_pkg::*;

  alu_fn_e      fn;
  logic         is_arith;
  logic         is_sub;
  logic         is_xor;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic         arith_carry;
  logic         arith_ovf;

  always_comb begin
    fn       = alu_fn_e'(op_sel);
    is_arith = (fn == FN_ADD) || (fn == FN_SUB);
    is_sub   = (fn == FN_SUB);
    is_xor   = (fn == FN_XOR);
  end

  alu_arith #(.W(WIDTH)) u_arith (
    .a         (opnd_x),
    .b         (opnd_y),
    .do_sub    (is_sub),
    .sum       (arith_res),
    .carry_out (arith_carry),
    .ovf       (arith_ovf)
  );

  alu_logic #(.W(WIDTH)) u_logic (
    .a        (opnd_x),
    .b        (opnd_y),
    .pick_xor (is_xor),
    .out      (logic_res)
  );

  assign result = is_arith ? arith_res : logic_res;

  alu_flags #(.W(WIDTH)) u_flags (
    .res       (result),
    .arith_en  (is_arith),
    .carry_raw (arith_carry),
    .ovf_raw   (arith_ovf),
    .zf        (flag_zero),
    .sf        (flag_neg),
    .cf        (flag_carry),
    .of        (flag_ovf)
  );

endmodule

// File: tb/sim_alu_cc_unit.sv
module sim_alu_cc_unit;

  logic        clk;
  logic [1:0]  op_sel;
  logic [31:0] opnd_x, opnd_y, result;
  logic        flag_ovf, flag_zero, flag_neg, flag_carry;
  int          n_checks, n_fail;
  bit          done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  alu_cc_unit u0 (
    .op_sel(op_sel), .opnd_x(opnd_x), .opnd_y(opnd_y), .result(result),
    .flag_ovf(flag_ovf), .flag_zero(flag_zero), .flag_neg(flag_neg),
    .flag_carry(flag_carry)
  );

  // Reference model written from the requirements: wide unsigned math.
  task automatic expect_vals(input logic [1:0] op, input logic [31:0] x, y,
                             output logic [31:0] r, output logic v, z, n, c);
    longint unsigned ux, uy, s;
    ux = longint'(x); uy = longint'(y);
    v = 1'b0; c = 1'b0;
    case (op)
      2'd0: begin
        s = ux + uy; r = s[31:0]; c = s[32];
        v = (x[31] == y[31]) && (r[31] != x[31]);
      end
      2'd1: begin
        s = ux - uy; r = s[31:0]; c = (uy > ux);
        v = (x[31] != y[31]) && (r[31] != x[31]);
      end
      2'd2: r = x & y;
      default: r = x ^ y;
    endcase
    z = (r == 32'd0);
    n = r[31];
  endtask

  task automatic chk(input string tag, input logic [31:0] act, exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [1:0] op, input logic [31:0] x, y,
                                 input string rtag, input string vtag,
                                 input string ctag);
    logic [31:0] r; logic v, z, n, c;
    @(negedge clk);
    op_sel = op; opnd_x = x; opnd_y = y;
    #1;
    expect_vals(op, x, y, r, v, z, n, c);
    chk(rtag, result, r);
    chk("R5 zero", {31'd0, flag_zero}, {31'd0, z});
    chk("R6 sign", {31'd0, flag_neg}, {31'd0, n});
    chk(vtag, {31'd0, flag_ovf}, {31'd0, v});
    chk(ctag, {31'd0, flag_carry}, {31'd0, c});
  endtask

  task automatic t_add;
    apply_and_check(2'd0, 32'd5, 32'd7, "R1 add", "R7 ovf", "R9 carry");
    apply_and_check(2'd0, 32'h7FFF_FFFF, 32'd1, "R1 add", "R7 ovf", "R9 carry");
    apply_and_check(2'd0, 32'h8000_0000, 32'h8000_0000, "R1 add", "R7 ovf", "R9 carry");
    apply_and_check(2'd0, 32'hFFFF_FFFF, 32'd1, "R1 add", "R7 ovf", "R9 carry");
    apply_and_check(2'd0, 32'h1234_5678, 32'h0, "R1 add", "R7 ovf", "R9 carry");
  endtask

  task automatic t_sub;
    apply_and_check(2'd1, 32'd9, 32'd4, "R2 sub", "R8 ovf", "R10 borrow");
    apply_and_check(2'd1, 32'd4, 32'd9, "R2 sub", "R8 ovf", "R10 borrow");
    apply_and_check(2'd1, 32'h8000_0000, 32'd1, "R2 sub", "R8 ovf", "R10 borrow");
    apply_and_check(2'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R2 sub", "R8 ovf", "R10 borrow");
    apply_and_check(2'd1, 32'hABCD_0000, 32'hABCD_0000, "R2 sub", "R8 ovf", "R10 borrow");
  endtask

  task automatic t_logic;
    apply_and_check(2'd2, 32'hF0F0_FFFF, 32'hFF00_8001, "R3 and", "R11 ovf", "R11 carry");
    apply_and_check(2'd2, 32'hAAAA_AAAA, 32'h5555_5555, "R3 and", "R11 ovf", "R11 carry");
    apply_and_check(2'd3, 32'hFFFF_FFFF, 32'h0000_0001, "R4 xor", "R11 ovf", "R11 carry");
    apply_and_check(2'd3, 32'h8000_0000, 32'h8000_0000, "R4 xor", "R11 ovf", "R11 carry");
  endtask

  // R12: operands held, only the code moves; no clock edge between changes.
  task automatic t_code_sweep;
    logic [31:0] r; logic v, z, n, c;
    @(negedge clk);
    opnd_x = 32'h8000_0000; opnd_y = 32'h8000_0000;
    for (int k = 0; k < 4; k++) begin
      op_sel = 2'(k);
      #1;
      expect_vals(2'(k), opnd_x, opnd_y, r, v, z, n, c);
      chk("R12 result", result, r);
      chk("R12 ovf", {31'd0, flag_ovf}, {31'd0, v});
      chk("R12 carry", {31'd0, flag_carry}, {31'd0, c});
    end
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    op_sel = 2'd0; opnd_x = '0; opnd_y = '0;
    #2;
    // Initial state: 0+0 gives zero result, zero flag set, others clear.
    chk("R5 initial zero", {28'd0, flag_zero, flag_neg, flag_ovf, flag_carry},
        32'h8);
    chk("R1 initial result", result, 32'd0);
    t_add;
    t_sub;
    t_logic;
    t_code_sweep;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule